// File: doc/BRIEF.md
# Clocked Three-Way Phase Comparator

This block compares a reference square wave with a feedback square wave, typically the divided output of an oscillator, and produces three independent phase-error signals for a loop filter. All of its work is done on one fast system clock. Both inputs are first brought into the clock domain and reduced to level and rising-edge strobes. Three detectors then read those strobes.

The first detector is a plain exclusive OR of the two levels. Its average value tracks phase difference, from zero for aligned inputs to full scale at half a period. The second detector looks only at rising edges and drives a single error line in one of three ways. It drives high while the reference leads, drives low while the feedback leads, and releases the line once the lagging edge has arrived. An output-enable bit stands in for the released, high-impedance condition. A lock flag is high exactly while the line is released. The third detector is a set/reset flop that the reference edge sets and the feedback edge clears. Its duty cycle spans the full period.

No inputs or outputs carry a data stream, so every pin is a plain level with no handshake.

Top module: `phase_cmp_unit`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `pfd_oe` is 0, `lock_flag` is 1, `sr_err` is 0 and `xor_err` is 0.
- R2: An input change made between two clock edges reaches the outputs on the third rising clock edge after it (SYNC_STAGES+1 edges; default 3), and not earlier.
- R3: `xor_err` equals `ref_in` XOR `cmp_in` as sampled three edges earlier: 1 when the levels differ and 0 when they match.
- R4: From the released state, a rising edge on `ref_in` alone sets `pfd_oe`=1 and `pfd_drive`=1. These hold until a rising edge on `cmp_in` returns the line to released (`pfd_oe`=0).
- R5: From the released state, a rising edge on `cmp_in` alone sets `pfd_oe`=1 and `pfd_drive`=0. These hold until a rising edge on `ref_in` releases the line.
- R6: Falling edges on either input have no effect on `pfd_oe`, `pfd_drive`, `lock_flag` or `sr_err`.
- R7: `lock_flag` is 1 exactly when `pfd_oe` is 0.
- R8: When both inputs rise in the same clock cycle, the edge detector ends released and `sr_err` ends 0, whatever the state before. Clearing has priority over setting.
- R9: A rising edge on `ref_in` sets `sr_err` to 1, and a rising edge on `cmp_in` clears it to 0.
- R10: While the line is driven, more rising edges on the leading input keep the same drive. A spurious reference edge holds it high, and a feedback input with no reference edges holds it low.
- R11: The error line never goes straight from driven high to driven low, or from low to high, without first being released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the compared signals |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference signal, asynchronous to clk |
| cmp_in | input | 1 | Feedback (comparison) signal, asynchronous to clk |
| xor_err | output | 1 | Exclusive-OR phase error |
| pfd_drive | output | 1 | Value driven on the edge-detector error line when enabled |
| pfd_oe | output | 1 | Enable for the error line; 0 means released |
| lock_flag | output | 1 | High while the error line is released |
| sr_err | output | 1 | Set/reset detector output |

## Verification
The checker holds on every cycle the relations that need no scenario: the lock flag against the enable, the reset values, the XOR output against the inputs three edges back, and the rule that the drive never flips sign without a release. Only the directed scenarios can show which input leads, the exact edge on which the line changes, that falling edges and repeated leading edges do nothing, and the outcome of simultaneous edges. Those cases depend on a history of edges that a simple property cannot follow.

// File: rtl/pc_pkg.sv
package pc_pkg;
  typedef enum logic [1:0] {
    PD_REL = 2'd0,
    PD_UP  = 2'd1,
    PD_DN  = 2'd2
  } pd_state_t;

  localparam int CH_REF = 0;
  localparam int CH_CMP = 1;
  localparam int N_CH   = 2;
endpackage

// File: rtl/pc_sync_edge.sv
module pc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      last  <= 1'b0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      last  <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
  assign rise  = chain[STAGES-1] & ~last;
endmodule

// File: rtl/pc_edge_det.sv
module pc_edge_det
  import pc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic cmp_rise,
  output logic drive,
  output logic oe,
  output logic lock
);
  pd_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    if (ref_rise && cmp_rise) begin
      st_nx = PD_REL;
    end else begin
      unique case (st)
        PD_REL: begin
          if (ref_rise)      st_nx = PD_UP;
          else if (cmp_rise) st_nx = PD_DN;
        end
        PD_UP:   if (cmp_rise) st_nx = PD_REL;
        PD_DN:   if (ref_rise) st_nx = PD_REL;
        default: st_nx = PD_REL;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= PD_REL;
      drive <= 1'b0;
      oe    <= 1'b0;
      lock  <= 1'b1;
    end else begin
      st    <= st_nx;
      drive <= (st_nx == PD_UP);
      oe    <= (st_nx != PD_REL);
      lock  <= (st_nx == PD_REL);
    end
  end
endmodule

// File: rtl/pc_sr_det.sv
module pc_sr_det (
  input  logic clk,
  input  logic rst,
  input  logic ref_rise,
  input  logic cmp_rise,
  output logic q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= 1'b0;
    else if (cmp_rise) q <= 1'b0;
    else if (ref_rise) q <= 1'b1;
  end
endmodule

// File: rtl/phase_cmp_unit.sv
module phase_cmp_unit
  import pc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic cmp_in,
  output logic xor_err,
  output logic pfd_drive,
  output logic pfd_oe,
  output logic lock_flag,
  output logic sr_err
);
  logic [N_CH-1:0] raw, lvl, rse;

  assign raw[CH_REF] = ref_in;
  assign raw[CH_CMP] = cmp_in;

  for (genvar i = 0; i < N_CH; i++) begin : g_in
    pc_sync_edge #(.STAGES(SYNC_STAGES)) u_se (
      .clk  (clk),
      .rst  (rst),
      .din  (raw[i]),
      .level(lvl[i]),
      .rise (rse[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) xor_err <= 1'b0;
    else     xor_err <= lvl[CH_REF] ^ lvl[CH_CMP];
  end

  pc_edge_det u_pfd (
    .clk     (clk),
    .rst     (rst),
    .ref_rise(rse[CH_REF]),
    .cmp_rise(rse[CH_CMP]),
    .drive   (pfd_drive),
    .oe      (pfd_oe),
    .lock    (lock_flag)
  );

  pc_sr_det u_sr (
    .clk     (clk),
    .rst     (rst),
    .ref_rise(rse[CH_REF]),
    .cmp_rise(rse[CH_CMP]),
    .q       (sr_err)
  );
endmodule

// File: rtl/pc_unit_checker.sv
module pc_unit_checker (
  input logic clk,
  input logic rst,
  input logic ref_in,
  input logic cmp_in,
  input logic xor_err,
  input logic pfd_drive,
  input logic pfd_oe,
  input logic lock_flag,
  input logic sr_err
);
  logic [1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst)                 since_rst <= 2'd0;
    else if (since_rst != 3) since_rst <= since_rst + 2'd1;
  end

  assert_lock_is_release_R7: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 0) |-> (lock_flag == !pfd_oe));

  assert_reset_values_R1: assert property (@(posedge clk)
    (since_rst == 1) |-> (!pfd_oe && lock_flag && !sr_err && !xor_err));

  assert_xor_latency_R3: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 3) |-> (xor_err == ($past(ref_in, 3) ^ $past(cmp_in, 3))));

  assert_no_up_to_dn_R11: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 0 && pfd_oe && pfd_drive) |=> !(pfd_oe && !pfd_drive));

  assert_no_dn_to_up_R11: assert property (@(posedge clk) disable iff (rst)
    (since_rst != 0 && pfd_oe && !pfd_drive) |=> !(pfd_oe && pfd_drive));
endmodule

bind phase_cmp_unit pc_unit_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .ref_in   (ref_in),
  .cmp_in   (cmp_in),
  .xor_err  (xor_err),
  .pfd_drive(pfd_drive),
  .pfd_oe   (pfd_oe),
  .lock_flag(lock_flag),
  .sr_err   (sr_err)
);

// File: tb/sim_phase_cmp_unit.sv
module sim_phase_cmp_unit;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic cmp_in = 1'b0;
  logic xor_err, pfd_drive, pfd_oe, lock_flag, sr_err;
  int   n_chk = 0;
  int   n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phase_cmp_unit u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .cmp_in(cmp_in),
    .xor_err(xor_err), .pfd_drive(pfd_drive), .pfd_oe(pfd_oe),
    .lock_flag(lock_flag), .sr_err(sr_err)
  );

  task automatic chk(input logic [3:0] act, input logic [3:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b (oe,drive,lock,sr)", req, act, exp);
    end
  endtask

  function automatic logic [3:0] pfd_now();
    return {pfd_oe, pfd_drive, lock_flag, sr_err};
  endfunction

  // set inputs at a falling edge, then let three rising edges pass
  task automatic apply(input logic r, input logic c);
    @(negedge clk);
    ref_in = r;
    cmp_in = c;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pfd_now(), 4'b0010, "R1 reset state");
    chk({3'b0, xor_err}, 4'b0, "R1 xor at reset");
  endtask

  task automatic t_latency_ref_lead();
    @(negedge clk);
    ref_in = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(pfd_now(), 4'b0010, "R2 no change after two edges");
    @(posedge clk);
    @(negedge clk);
    chk(pfd_now(), 4'b1101, "R2 R4 R9 ref leads, drive high");
    chk({3'b0, xor_err}, 4'b1, "R3 levels differ");
    apply(1'b1, 1'b1);
    chk(pfd_now(), 4'b0010, "R4 R7 R9 cmp edge releases");
    chk({3'b0, xor_err}, 4'b0, "R3 levels match high");
    apply(1'b0, 1'b1);
    chk({3'b0, xor_err}, 4'b1, "R3 cmp high only");
    chk(pfd_now(), 4'b0010, "R6 ref fall ignored");
    apply(1'b0, 1'b0);
    chk(pfd_now(), 4'b0010, "R6 cmp fall ignored");
  endtask

  task automatic t_cmp_lead();
    apply(1'b0, 1'b1);
    chk(pfd_now(), 4'b1000, "R5 cmp leads, drive low");
    apply(1'b1, 1'b1);
    chk(pfd_now(), 4'b0011, "R5 R9 ref edge releases and sets sr");
    apply(1'b0, 1'b0);
  endtask

  task automatic t_duty_spurious();
    apply(1'b1, 1'b0);
    chk(pfd_now(), 4'b1101, "R4 ref leads again");
    apply(1'b0, 1'b0);
    chk(pfd_now(), 4'b1101, "R6 ref fall keeps high drive");
    apply(1'b1, 1'b0);
    chk(pfd_now(), 4'b1101, "R10 spurious ref edge keeps high");
    apply(1'b1, 1'b1);
    chk(pfd_now(), 4'b0010, "R4 release after cmp");
    apply(1'b0, 1'b0);
  endtask

  task automatic t_no_ref();
    for (int k = 0; k < 3; k++) begin
      apply(1'b0, 1'b1);
      chk(pfd_now(), 4'b1000, "R10 cmp only stays low");
      apply(1'b0, 1'b0);
    end
    apply(1'b1, 1'b0);
    chk(pfd_now(), 4'b0011, "R5 ref releases low drive");
    apply(1'b0, 1'b0);
  endtask

  task automatic t_both();
    apply(1'b1, 1'b0);
    chk(pfd_now(), 4'b1101, "R8 set up drive high first");
    apply(1'b0, 1'b0);
    apply(1'b1, 1'b1);
    chk(pfd_now(), 4'b0010, "R8 coincident edges release and clear");
    apply(1'b0, 1'b0);
    apply(1'b1, 1'b1);
    chk(pfd_now(), 4'b0010, "R8 coincident edges from released");
    apply(1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(pfd_now(), 4'b0010, "R1 first cycle after reset");
    t_latency_ref_lead();
    t_cmp_lead();
    t_duty_spurious();
    t_no_ref();
    t_both();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule